// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block sits behind an external two-ratio prescaler. That prescaler divides by either P or P+1. The block counts the prescaler's output pulses and produces one feedback pulse for the phase detector every N·P + A input cycles. Each prescaler output pulse arrives as a one-cycle clock enable. A main counter and a swallow counter both step down on every such pulse. While the swallow count is still nonzero, the modulus line asks the prescaler for P+1. Once the swallow count is used up, the modulus line asks for P for the rest of the cycle. When the main count runs out, both counters reload and a new cycle starts.

The main count and the swallow count are programmed through a load strobe. A new pair of values is held in a staging register and only takes effect when the counters next reload, so an output cycle that is already under way is never disturbed. When P is a power of two, 2^b, a wanted total ratio T can be programmed directly. The low b bits of T become the swallow count and the remaining upper bits become the main count.

Top module: `swallow_fb_divider`

## Requirements
- R1: After synchronous reset, `mod_ctrl` is 1 (divide by P) and `fb_out` is 0.
- R2: With an effective main count Ne and swallow count A < Ne, `mod_ctrl` is 0 (divide by P+1) for exactly the first A prescaler groups of a cycle and 1 for the remaining Ne−A groups.
- R3: The distance between consecutive feedback pulses, measured in prescaler input cycles, is Ne·P + min(A, Ne).
- R4: Each cycle contains exactly Ne prescaler pulses. `fb_out` rises on the pulse that ends the cycle and stays high for exactly one prescaler group, which is P+1 input cycles if the next cycle starts with a swallow group and P otherwise.
- R5: With A = 0, `mod_ctrl` stays 1 for every group of the cycle.
- R6: With A ≥ Ne, `mod_ctrl` stays 0 for every group of the cycle, and the cycle still ends after Ne groups.
- R7: A load applied between reloads does not change the cycle in progress. The staged values take effect at the next reload.
- R8: A main count programmed as 0 acts as 1, so every prescaler pulse ends a cycle.
- R9: With P = 2^b, programming the main count as T >> b and the swallow count as T mod P gives a total ratio of exactly T.
- R10: In a clock cycle with no prescaler pulse, the counters, `mod_ctrl` and `fb_out` hold their values, whether or not a load is present.
- R11: A load presented in the same cycle as the pulse that ends a cycle is used for the reload made by that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| psc_pulse | input | 1 | Prescaler output pulse, one-cycle clock enable |
| main_cfg | input | 10 | Main count to stage (0 acts as 1) |
| swallow_cfg | input | 7 | Swallow count to stage |
| cfg_load | input | 1 | Captures main_cfg and swallow_cfg into staging |
| mod_ctrl | output | 1 | Modulus select: 0 = divide by P+1, 1 = divide by P |
| fb_out | output | 1 | Divided feedback output, high for one prescaler group per cycle |

## Verification
`mod_ctrl` and `fb_out` are registers that change only on the edge that samples a prescaler pulse, so each result is due one edge after that pulse. The bench reads them 1 ns after the rising edge. The bench's prescaler model reads `mod_ctrl` right after each pulse to choose the length of the next group. Cycle length, group count, swallow-group count and feedback width are accumulated between the edges on which a pulse coincides with a high `fb_out`. New values are loaded two clocks after such an edge. The cycle that ends next is therefore checked against the old values, and the cycle after it against the new ones.

// File: rtl/swallow_div_pkg.sv
package swallow_div_pkg;

    localparam int unsigned MAIN_W_DEF    = 10;
    localparam int unsigned SWALLOW_W_DEF = 7;

    // Modulus request presented to the external prescaler.
    typedef enum logic {
        MOD_PLUS_ONE = 1'b0,
        MOD_BASE     = 1'b1
    } modsel_e;

    // Per-cycle step information shared between the two counters.
    typedef struct packed {
        logic adv;   // prescaler pulse present this cycle
        logic last;  // this pulse closes the output cycle
    } step_t;

    // A remaining-group count of 0 or 1 means the current pulse is the last one.
    function automatic logic at_terminal(input logic [31:0] remaining);
        return remaining <= 32'd1;
    endfunction

    // Saturating decrement used by the swallow counter.
    function automatic logic [31:0] dec_sat(input logic [31:0] v);
        return (v == 32'd0) ? 32'd0 : v - 32'd1;
    endfunction

endpackage

// File: rtl/swallow_cfg_stage.sv
module swallow_cfg_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic [W-1:0] reload_o
);
    logic [W-1:0] held_q;

    always_ff @(posedge clk) begin
        if (rst)         held_q <= '0;
        else if (load_i) held_q <= value_i;
    end

    // A value presented together with the closing pulse is used at once.
    assign reload_o = load_i ? value_i : held_q;

    assert_stage_capture_R7: assert property (@(posedge clk) disable iff (rst)
        load_i |=> held_q == $past(value_i));

endmodule

// File: rtl/swallow_main_counter.sv
module swallow_main_counter
    import swallow_div_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic [W-1:0] reload_i,
    output step_t        step_o,
    output logic         fb_o
);
    logic [W-1:0] n_q;
    logic         fb_q;
    logic         last;

    assign last        = tick_i && at_terminal(32'(n_q));
    assign step_o.adv  = tick_i;
    assign step_o.last = last;

    always_ff @(posedge clk) begin
        if (rst) begin
            n_q  <= '0;
            fb_q <= 1'b0;
        end else if (tick_i) begin
            n_q  <= last ? reload_i : n_q - 1'b1;
            fb_q <= last;
        end
    end

    assign fb_o = fb_q;

    assert_fb_from_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(fb_q) |-> $past(tick_i));

    assert_main_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(n_q));

endmodule

// File: rtl/swallow_aux_counter.sv
module swallow_aux_counter
    import swallow_div_pkg::*;
#(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  step_t        step_i,
    input  logic [W-1:0] reload_i,
    output modsel_e      mod_o
);
    logic [W-1:0] a_q;
    logic [W-1:0] a_next;
    modsel_e      mod_q;

    always_comb begin
        if (step_i.last) a_next = reload_i;
        else             a_next = W'(dec_sat(32'(a_q)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            mod_q <= MOD_BASE;
        end else if (step_i.adv) begin
            a_q   <= a_next;
            mod_q <= (a_next == '0) ? MOD_BASE : MOD_PLUS_ONE;
        end
    end

    assign mod_o = mod_q;

    // Swallow groups begin only at a reload.
    assert_swallow_start_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(mod_q) |-> $past(step_i.last));

    assert_mod_change_on_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        !step_i.adv |=> $stable(mod_q) && $stable(a_q));

endmodule

// File: rtl/swallow_fb_divider.sv
module swallow_fb_divider
    import swallow_div_pkg::*;
#(
    parameter int unsigned MAIN_W    = MAIN_W_DEF,
    parameter int unsigned SWALLOW_W = SWALLOW_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 psc_pulse,
    input  logic [MAIN_W-1:0]    main_cfg,
    input  logic [SWALLOW_W-1:0] swallow_cfg,
    input  logic                 cfg_load,
    output logic                 mod_ctrl,
    output logic                 fb_out
);
    logic [MAIN_W-1:0]    main_reload;
    logic [SWALLOW_W-1:0] swallow_reload;
    step_t                step;
    modsel_e              mod_sel;

    swallow_cfg_stage #(.W(MAIN_W)) u_main_stage (
        .clk      (clk),
        .rst      (rst),
        .load_i   (cfg_load),
        .value_i  (main_cfg),
        .reload_o (main_reload)
    );

    swallow_cfg_stage #(.W(SWALLOW_W)) u_swallow_stage (
        .clk      (clk),
        .rst      (rst),
        .load_i   (cfg_load),
        .value_i  (swallow_cfg),
        .reload_o (swallow_reload)
    );

    swallow_main_counter #(.W(MAIN_W)) u_main_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (psc_pulse),
        .reload_i (main_reload),
        .step_o   (step),
        .fb_o     (fb_out)
    );

    swallow_aux_counter #(.W(SWALLOW_W)) u_swallow_cnt (
        .clk      (clk),
        .rst      (rst),
        .step_i   (step),
        .reload_i (swallow_reload),
        .mod_o    (mod_sel)
    );

    assign mod_ctrl = (mod_sel == MOD_BASE);

    assert_stall_outputs_R10: assert property (@(posedge clk) disable iff (rst)
        !psc_pulse |=> $stable(mod_ctrl) && $stable(fb_out));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> mod_ctrl && !fb_out);

endmodule

// File: tb/swallow_fb_divider_bench.sv
module swallow_fb_divider_bench;
    localparam int PB = 3;
    localparam int P  = 1 << PB;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst = 1'b1;
    logic       auto_en = 1'b0, auto_tick = 1'b0, man_tick = 1'b0;
    logic [9:0] n_in = '0;
    logic [6:0] a_in = '0;
    logic       load = 1'b0;
    logic       psc;
    logic       mod_ctrl, fb_out;

    assign psc = auto_en ? auto_tick : man_tick;

    swallow_fb_divider u_swallow_fb_divider (
        .clk(clk), .rst(rst), .psc_pulse(psc), .main_cfg(n_in),
        .swallow_cfg(a_in), .cfg_load(load), .mod_ctrl(mod_ctrl), .fb_out(fb_out)
    );

    int checks = 0, errors = 0;

    function automatic int eff_n(input int n); return (n == 0) ? 1 : n; endfunction
    function automatic int low_grp(input int n, input int a);
        return (a < eff_n(n)) ? a : eff_n(n);
    endfunction
    function automatic int ratio(input int n, input int a);
        return eff_n(n) * P + low_grp(n, a);
    endfunction
    function automatic int first_div(input int n, input int a);
        return (low_grp(n, a) > 0) ? P + 1 : P;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Prescaler model: group length chosen from mod_ctrl right after each pulse.
    initial begin
        forever begin
            @(negedge clk);
            auto_tick = 1'b0;
            if (auto_en) begin
                int div;
                div = mod_ctrl ? P : P + 1;
                repeat (div - 1) @(negedge clk);
                auto_tick = 1'b1;
            end
        end
    end

    // Cycle monitor: a cycle closes on an edge where a pulse leaves fb_out high.
    int cur_clks = 0, cur_grp = 0, cur_low = 0, cur_fbh = 0;
    int rec_clks = 0, rec_grp = 0, rec_low = 0, rec_fbh = 0;
    logic prev_mod = 1'b1;
    event term_ev;
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst) begin
                cur_clks = 0; cur_grp = 0; cur_low = 0; cur_fbh = 0; prev_mod = 1'b1;
            end else begin
                cur_clks++;
                if (fb_out) cur_fbh++;
                if (psc) begin
                    cur_grp++;
                    if (!prev_mod) cur_low++;
                end
                if (psc && fb_out) begin
                    rec_clks = cur_clks; rec_grp = cur_grp; rec_low = cur_low; rec_fbh = cur_fbh;
                    cur_clks = 0; cur_grp = 0; cur_low = 0; cur_fbh = 0;
                    -> term_ev;
                end
                prev_mod = mod_ctrl;
            end
        end
    end

    int cur_n = 0, cur_a = 0;

    task automatic run_cfg(input int n, input int a);
        @(term_ev);
        repeat (2) @(negedge clk);
        n_in = 10'(n); a_in = 7'(a); load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        @(term_ev);
        chk("R7 old cycle kept", rec_clks, ratio(cur_n, cur_a));
        @(term_ev);
        chk("R3 period", rec_clks, ratio(n, a));
        chk("R2 swallow groups", rec_low, low_grp(n, a));
        chk("R4 groups per cycle", rec_grp, eff_n(n));
        chk("R4 fb width", rec_fbh, first_div(n, a));
        cur_n = n; cur_a = a;
    endtask

    task automatic man_step(input bit with_load, input int n, input int a);
        @(negedge clk);
        man_tick = 1'b1;
        if (with_load) begin n_in = 10'(n); a_in = 7'(a); load = 1'b1; end
        @(negedge clk);
        man_tick = 1'b0; load = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=190000 expected=fewer cycles");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mod after reset", int'(mod_ctrl), 1);
        chk("R1 fb after reset", int'(fb_out), 0);

        // Load on the closing pulse (counters start exhausted after reset).
        man_step(1'b1, 4, 2);
        chk("R11 mod after same-edge load", int'(mod_ctrl), 0);
        chk("R11 fb on closing pulse", int'(fb_out), 1);
        man_step(1'b0, 0, 0);
        chk("R2 second swallow group", int'(mod_ctrl), 0);
        chk("R4 fb low after one group", int'(fb_out), 0);
        man_step(1'b0, 0, 0);
        chk("R2 swallow exhausted", int'(mod_ctrl), 1);

        // Stall with a load present: nothing moves.
        @(negedge clk);
        n_in = 10'd9; a_in = 7'd9; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        repeat (20) @(negedge clk);
        chk("R10 mod held", int'(mod_ctrl), 1);
        chk("R10 fb held", int'(fb_out), 0);
        man_step(1'b0, 0, 0);
        chk("R7 mid-cycle load ignored", int'(mod_ctrl), 1);
        chk("R4 no early fb", int'(fb_out), 0);
        man_step(1'b0, 0, 0);
        chk("R4 fb after four groups", int'(fb_out), 1);
        chk("R7 staged swallow applied", int'(mod_ctrl), 0);
        cur_n = 9; cur_a = 9;

        @(negedge clk);
        auto_en = 1'b1;

        run_cfg(5, 0);
        chk("R5 no swallow groups", rec_low, 0);
        run_cfg(6, 6);
        chk("R6 all swallow", rec_low, 6);
        run_cfg(4, 9);
        chk("R6 swallow exceeds main", rec_low, 4);
        chk("R6 cycle length", rec_grp, 4);
        run_cfg(0, 3);
        chk("R8 zero main count", rec_grp, 1);
        run_cfg(1, 0);
        chk("R8 one group", rec_grp, 1);
        run_cfg(1023, 127);

        for (int i = 0; i < 30; i++) begin
            int n, a;
            n = $urandom_range(0, 40);
            a = $urandom_range(0, 60);
            run_cfg(n, a);
        end

        for (int i = 0; i < 6; i++) begin
            int t;
            t = P * P + $urandom_range(0, 400);
            run_cfg(t >> PB, t & (P - 1));
            chk("R9 binary split total", rec_clks, t);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule